// File: doc/BRIEF.md
# AGC Gain Step Controller

This block decides the gain code for a programmable-gain audio stage. An external detector supplies the envelope of the input signal as a signed level in half-decibel units. The block predicts the output level as that level plus the current gain. It then moves the gain up or down by a single half-decibel code, and never faster than its three interval timers allow. A slow periodic tick paces the timers, so the same logic runs from any system clock.

A two-bit mode input selects the behaviour. The first mode bypasses the control loop at a fixed gain. The second mode only limits the output. The third adds 2:1 compression toward a target that depends on the level. The fourth also mutes and freezes the gain while the input is below a noise floor. A cut on the first limiter overshoot takes effect at once, and further cuts are paced by an attack interval. Rises wait for both a hold interval and a long release interval. Every gain change restarts all three timers.

Top module: `agc_step_ctrl`

## Requirements
- R1: After reset, gain_o is 12 (6 dB) and mute_o is 0. On the first clock edge at which mode_i differs from its value at the previous edge, the gain reloads to 12. That same edge leaves the attack timer expired and loads the hold and release timers to their full lengths.
- R2: Mode encoding is 00 = fixed, 01 = limit only, 10 = limit plus compression, 11 = limit, compression and noise gate. In mode 00 the gain stays at 12 and mute_o stays 0 whatever level_i is.
- R3: Apart from a reload, every gain change moves gain_o by exactly one code, which is 0.5 dB.
- R4: The predicted output is level_i + gain_o, in 0.5 dB units. When it exceeds the limit level (default 18, which is 9 dBV) and the attack timer has expired, the gain drops by one code at the next edge. That edge restarts all three timers.
- R5: While the attack timer is running, an overshoot leaves the gain unchanged. The next cut lands on the edge after ATTACK_TICKS ticks have been counted.
- R6: The timers advance only on cycles with tick_i = 1. With tick_i held at 0, a pending cut or rise never happens.
- R7: A rise of one code needs three things: the hold and release timers have both expired, the prediction does not exceed the target, and the prediction is at most target − 2. The last condition is a one-code hysteresis band, so a constant input leaves the gain still.
- R8: The gain never goes below 0. It never rises above 12 in mode 01 or above MAX_CODE (default 60, which is 30 dB) in modes 10 and 11.
- R9: In modes 10 and 11 the target is min(LIMIT, LIMIT − ((COMP_REF − level_i) >>> 1)), with COMP_REF defaulting to −20. Each 1 dB of input change below the knee therefore moves the target output by 0.5 dB. In mode 01 the target is LIMIT.
- R10: In mode 11, level_i < GATE_LVL (default −68, about −34 dBV) sets mute_o at the next edge and freezes the gain. A level equal to GATE_LVL does not gate. Modes 01 and 10 never mute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe that advances the interval timers |
| mode_i | input | 2 | Mode select (00 fixed, 01 limit, 10 compress, 11 compress and gate) |
| level_i | input | LVL_W | Signed input envelope level in 0.5 dB units |
| gain_o | output | GAIN_W | Gain code in 0.5 dB units, from 0 to MAX_CODE |
| mute_o | output | 1 | Noise-gate mute flag |

## Verification
The bench checks the attack window from both sides. A design that cut on every overshoot would show the second cut three cycles early. A design that also delayed the first cut would miss the cut that should be immediate. A constant level that sits exactly on the limit must leave the gain frozen, so a design without the hysteresis band would toggle between adjacent codes. Other corners include the compression ceiling being clamped at 60 and the floor at 0. The gate is probed at exactly −68 and at −69, which exposes an inclusive or exclusive comparison that is wrong. A run with the tick held low shows whether the timers count clock cycles instead of ticks.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    AGC_OFF   = 2'b00,
    AGC_LIMIT = 2'b01,
    AGC_COMP  = 2'b10,
    AGC_GATE  = 2'b11
  } agc_mode_e;

  // predicted output level = input level + current gain (0.5 dB units)
  function automatic int predict_level(input int lvl, input int gain);
    return lvl + gain;
  endfunction

  // 2:1 compression curve, never above the limiter level
  function automatic int comp_target(input int lvl, input int ref_lvl, input int lim);
    int t;
    t = lim - ((ref_lvl - lvl) >>> 1);
    return (t > lim) ? lim : t;
  endfunction

endpackage

// File: rtl/agc_interval_timer.sv
module agc_interval_timer #(
  parameter int COUNT         = 64,
  parameter bit START_EXPIRED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  input  logic rearm_i,
  output logic expired_o
);
  localparam int CW = $clog2(COUNT + 1);
  localparam logic [CW-1:0] FULL = CW'(COUNT);
  localparam logic [CW-1:0] INIT = START_EXPIRED ? '0 : FULL;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= INIT;
    else if (rearm_i)                cnt_q <= INIT;
    else if (restart_i)              cnt_q <= FULL;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R5: a restart always opens a fresh, non-empty interval
  a_r5_restart_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !rearm_i) |=> !expired_o);

  // R6: with no tick and no reload the count does not move
  a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i && !rearm_i) |=> $stable(cnt_q));

endmodule

// File: rtl/agc_decide.sv
module agc_decide
  import agc_pkg::*;
#(
  parameter int LVL_W      = 10,
  parameter int GAIN_W     = 6,
  parameter int MAX_CODE   = 60,
  parameter int FIXED_CODE = 12,
  parameter int LIMIT_LVL  = 18,
  parameter int COMP_REF   = -20,
  parameter int GATE_LVL   = -68
) (
  input  agc_mode_e          mode_i,
  input  logic signed [LVL_W-1:0] level_i,
  input  logic [GAIN_W-1:0]  gain_i,
  input  logic               atk_done_i,
  input  logic               hold_done_i,
  input  logic               rel_done_i,
  output logic               over_o,
  output logic               gate_o,
  output logic               step_dn_o,
  output logic               step_up_o
);
  int  lvl, gain, pred, target, ceiling;
  logic active, room;

  always_comb begin
    lvl     = int'(level_i);
    gain    = int'(gain_i);
    pred    = predict_level(lvl, gain);
    target  = (mode_i == AGC_LIMIT) ? LIMIT_LVL
                                    : comp_target(lvl, COMP_REF, LIMIT_LVL);
    ceiling = (mode_i == AGC_LIMIT) ? FIXED_CODE : MAX_CODE;
    active  = (mode_i != AGC_OFF);
    over_o  = active && (pred > LIMIT_LVL);
    room    = (pred <= target - 2);
    gate_o  = (mode_i == AGC_GATE) && (lvl < GATE_LVL);
    step_dn_o = active && !gate_o && over_o && atk_done_i && (gain > 0);
    step_up_o = active && !gate_o && !over_o && room && hold_done_i
                && rel_done_i && (gain < ceiling);
  end

  // R3: never asks for both directions
  always_comb begin
    a_r3_one_direction: assert ($onehot0({step_dn_o, step_up_o}));
  end

endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl
  import agc_pkg::*;
#(
  parameter int LVL_W         = 10,
  parameter int MAX_CODE      = 60,
  parameter int FIXED_CODE    = 12,
  parameter int LIMIT_LVL     = 18,
  parameter int COMP_REF      = -20,
  parameter int GATE_LVL      = -68,
  parameter int ATTACK_TICKS  = 64,
  parameter int HOLD_TICKS    = 500,
  parameter int RELEASE_TICKS = 18100,
  localparam int GAIN_W       = $clog2(MAX_CODE + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic [1:0]              mode_i,
  input  logic signed [LVL_W-1:0] level_i,
  output logic [GAIN_W-1:0]       gain_o,
  output logic                    mute_o
);
  localparam int NUM_TIMERS = 3;
  localparam int TIMER_LEN [NUM_TIMERS] = '{ATTACK_TICKS, HOLD_TICKS, RELEASE_TICKS};
  localparam logic [GAIN_W-1:0] FIXED_G = GAIN_W'(FIXED_CODE);

  agc_mode_e mode, mode_q;
  logic [GAIN_W-1:0] gain_q;
  logic mute_q;
  logic [NUM_TIMERS-1:0] done;
  logic mode_chg, rearm, restart;
  logic over_w, gate_w, step_dn, step_up;

  assign mode     = agc_mode_e'(mode_i);
  assign mode_chg = (mode != mode_q);
  assign rearm    = mode_chg || (mode == AGC_OFF);
  assign restart  = step_dn || step_up;

  // attack starts expired; hold and release start full
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    agc_interval_timer #(
      .COUNT(TIMER_LEN[i]),
      .START_EXPIRED(i == 0)
    ) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .restart_i(restart), .rearm_i(rearm), .expired_o(done[i])
    );
  end

  agc_decide #(
    .LVL_W(LVL_W), .GAIN_W(GAIN_W), .MAX_CODE(MAX_CODE),
    .FIXED_CODE(FIXED_CODE), .LIMIT_LVL(LIMIT_LVL),
    .COMP_REF(COMP_REF), .GATE_LVL(GATE_LVL)
  ) u_dec (
    .mode_i(mode), .level_i(level_i), .gain_i(gain_q),
    .atk_done_i(done[0]), .hold_done_i(done[1]), .rel_done_i(done[2]),
    .over_o(over_w), .gate_o(gate_w),
    .step_dn_o(step_dn), .step_up_o(step_up)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AGC_OFF;
      gain_q <= FIXED_G;
      mute_q <= 1'b0;
    end else begin
      mode_q <= mode;
      mute_q <= gate_w;
      if (rearm)        gain_q <= FIXED_G;
      else if (step_dn) gain_q <= gain_q - 1'b1;
      else if (step_up) gain_q <= gain_q + 1'b1;
    end
  end

  assign gain_o = gain_q;
  assign mute_o = mute_q;

  // R1: a mode change reloads the fixed gain
  a_r1_mode_reload: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (gain_q == FIXED_G));

  // R2: fixed mode pins the gain and never mutes
  a_r2_fixed_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AGC_OFF) |=> (gain_q == FIXED_G && !mute_q));

  // R3: outside a reload the gain moves by at most one code
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !rearm |=> (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1
                || gain_q == $past(gain_q) - 1'b1));

  // R4: an allowed cut lands on the next edge and restarts the attack
  a_r4_cut_now: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !rearm) |=> (gain_q == $past(gain_q) - 1'b1 && !done[0]));

  // R5: overshoot during the attack window leaves the gain alone
  a_r5_attack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (over_w && !done[0] && !rearm) |=> $stable(gain_q));

  // R7: a rise restarts every timer, so two rises never abut
  a_r7_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !rearm) |=> (!step_up && !done[1] && !done[2]));

  // R8: gain stays within its code range
  a_r8_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GAIN_W'(MAX_CODE));

  // R10: gated cycles freeze the gain and raise mute
  a_r10_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_w && !rearm) |=> ($stable(gain_q) && mute_q));

endmodule

// File: tb/agc_step_ctrl_test.sv
module agc_step_ctrl_test;

  localparam int ATK = 3, HLD = 4, REL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [1:0] mode = 2'b00;
  logic signed [9:0] level = '0;
  logic [5:0] gain;
  logic mute;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  agc_step_ctrl #(
    .ATTACK_TICKS(ATK), .HOLD_TICKS(HLD), .RELEASE_TICKS(REL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode),
    .level_i(level), .gain_o(gain), .mute_o(mute)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [9:0]  lvl;
    logic        tk;
    logic [15:0] wt;
    logic [5:0]  g;
    logic        m;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{2'b00,  10'sd100, 1'b1, 16'd20,  6'd12, 1'b0, 4'd2},  // R2 fixed mode ignores level
    '{2'b01,  10'sd0,   1'b1, 16'd10,  6'd12, 1'b0, 4'd8},  // R8 limit-only ceiling 12
    '{2'b01,  10'sd10,  1'b1, 16'd1,   6'd11, 1'b0, 4'd4},  // R4 first overshoot cuts at once
    '{2'b01,  10'sd10,  1'b1, 16'd3,   6'd11, 1'b0, 4'd5},  // R5 attack window blocks cut
    '{2'b01,  10'sd10,  1'b1, 16'd1,   6'd10, 1'b0, 4'd5},  // R5 cut after attack
    '{2'b01,  10'sd10,  1'b1, 16'd8,   6'd8,  1'b0, 4'd3},  // R3 one code per cut
    '{2'b01,  10'sd10,  1'b1, 16'd30,  6'd8,  1'b0, 4'd7},  // R7 on the limit: no toggle
    '{2'b01,  10'sd12,  1'b1, 16'd1,   6'd7,  1'b0, 4'd4},  // R4 expired attack, immediate cut
    '{2'b01,  10'sd12,  1'b0, 16'd20,  6'd7,  1'b0, 4'd6},  // R6 no tick, attack never ends
    '{2'b01,  10'sd12,  1'b1, 16'd4,   6'd6,  1'b0, 4'd6},  // R6 ticks resume
    '{2'b01,  10'sd0,   1'b1, 16'd6,   6'd6,  1'b0, 4'd7},  // R7 release still running
    '{2'b01,  10'sd0,   1'b1, 16'd1,   6'd7,  1'b0, 4'd7},  // R7 rise after hold+release
    '{2'b01,  10'sd0,   1'b1, 16'd40,  6'd12, 1'b0, 4'd8},  // R8 stops at 12
    '{2'b01,  10'sd100, 1'b1, 16'd100, 6'd0,  1'b0, 4'd8},  // R8 floor at 0
    '{2'b10, -10'sd40,  1'b1, 16'd1,   6'd12, 1'b0, 4'd1},  // R1 mode change reloads
    '{2'b10, -10'sd40,  1'b1, 16'd299, 6'd47, 1'b0, 4'd9},  // R9 target 8 -> gain 47
    '{2'b10, -10'sd60,  1'b1, 16'd100, 6'd57, 1'b0, 4'd9},  // R9 2:1 slope -> gain 57
    '{2'b10, -10'sd80,  1'b1, 16'd100, 6'd60, 1'b0, 4'd8},  // R8 clamp at 60
    '{2'b10, -10'sd70,  1'b1, 16'd5,   6'd60, 1'b0, 4'd10}, // R10 no gate in mode 10
    '{2'b10,  10'sd0,   1'b1, 16'd1,   6'd59, 1'b0, 4'd4},  // R4 limiter in compression
    '{2'b01,  10'sd0,   1'b1, 16'd1,   6'd12, 1'b0, 4'd1},  // R1 reload from 59
    '{2'b11, -10'sd70,  1'b1, 16'd1,   6'd12, 1'b1, 4'd10}, // R10 gate mutes
    '{2'b11, -10'sd70,  1'b1, 16'd50,  6'd12, 1'b1, 4'd10}, // R10 gain frozen
    '{2'b11, -10'sd60,  1'b1, 16'd1,   6'd13, 1'b0, 4'd10}, // R10 gate opens, rise resumes
    '{2'b11, -10'sd68,  1'b1, 16'd1,   6'd13, 1'b0, 4'd10}, // R10 threshold itself not gated
    '{2'b11, -10'sd69,  1'b1, 16'd1,   6'd13, 1'b1, 4'd10}, // R10 one below gates
    '{2'b00,  10'sd50,  1'b1, 16'd1,   6'd12, 1'b0, 4'd2},  // R2 fixed mode reload
    '{2'b00,  10'sd50,  1'b1, 16'd20,  6'd12, 1'b0, 4'd2}   // R2 stays fixed
  };

  task automatic check(input string what, input int rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("reset gain", 1, int'(gain), 12);   // R1
    check("reset mute", 1, int'(mute), 0);    // R1
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      mode  = VEC[i].md;
      level = VEC[i].lvl;
      tick  = VEC[i].tk;
      repeat (int'(VEC[i].wt)) @(posedge clk);
      @(negedge clk);
      check($sformatf("vec %0d gain", i), int'(VEC[i].rq), int'(gain), int'(VEC[i].g));
      check($sformatf("vec %0d mute", i), int'(VEC[i].rq), int'(mute), int'(VEC[i].m));
    end

    // R1 directed: reset while the gain is away from 12
    mode = 2'b10; level = -10'sd80; tick = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("rise before reset", 9, int'(gain), 14);  // R9 rises at edges 8 and 15
    rst_n = 1'b0;
    @(negedge clk);
    check("async reset gain", 1, int'(gain), 12);   // R1
    check("async reset mute", 1, int'(mute), 0);    // R1
    mode = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("fixed after reset", 2, int'(gain), 12);  // R2
    finish_run();
  end

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule